// File: doc/BRIEF.md
# Lane-Masked Synchronous RAM with Selectable Collision Read

A single-clock memory with one write port and one read port. Each word is split into equal byte lanes, and a write changes only the lanes whose lane-enable bit is set while the global write enable is high. The lane width is a parameter (5, 8, 9 or 10 bits) and the word width must be a whole number of lanes. Lanes left out of a write keep what they held.

The read port is registered. A parameter picks what the output register takes when the read address equals the write address in a cycle where at least one lane is written (a collision): the merged new word, the word stored before the write, or its own previous value. Memory contents are not reset; only the output register clears.

Top module: `bmr_masked_ram`

## Requirements
- R1: A lane is written only when `wr_en` is 1 and that lane's bit of `wr_lanes` is 1; with `wr_en` at 0 the lane bits change nothing in memory.
- R2: Lane bit i governs data bits [(i+1)*LANE_W-1 : i*LANE_W]; for a 16-bit word with 8-bit lanes, `wr_lanes` = 2'b01 writes only bits [7:0] and 2'b11 writes all 16 bits.
- R3: Lanes not written keep their stored value, and a read of an address with no collision returns the stored word.
- R4: DATA_W must be an exact multiple of LANE_W and LANE_W must be 5, 8, 9 or 10; any other choice, or an unknown mode value, stops elaboration. Every lane of a legal configuration is writable on its own.
- R5: `rd_data` is loaded one clock after `rd_en` is sampled high; while `rd_en` is 0 it holds.
- R6: With RDW_MODE = RDW_NEW (encoding 0), a collision returns the new data in the written lanes and the stored data in the other lanes.
- R7: With RDW_MODE = RDW_OLD (encoding 1), a collision returns the whole word as stored before the write.
- R8: With RDW_MODE = RDW_HOLD (encoding 2), a collision leaves `rd_data` unchanged. A collision needs `rd_en` high, equal addresses and at least one lane actually written.
- R9: If the word is a single lane, `wr_lanes` is ignored and `wr_en` alone writes the word.
- R10: A synchronous `rst` clears `rd_data` to zero and does not alter memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the output register |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Global write enable |
| wr_lanes | input | LANE_EN_W | One enable bit per lane (one unused bit for a single-lane word) |
| rd_addr | input | ADDR_W | Read address |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds four copies side by side on a 16-word memory: 16-bit words with 8-bit lanes in new-data mode, 15-bit words with 5-bit lanes in old-data mode, 18-bit words with 9-bit lanes in hold mode, and a single 10-bit lane in new-data mode. Together they cover every legal lane width, all three collision modes, two- and three-lane masks, and the single-lane case where the lane enables are ignored. The sweep runs every lane-enable pattern with the write enable both on and off at every address, mixing collisions, plain reads and idle cycles, so each mode meets partial-mask collisions and zero-lane writes to the read address.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  // Read result when the read address is written in the same cycle.
  typedef enum logic [1:0] {
    RDW_NEW  = 2'd0,
    RDW_OLD  = 2'd1,
    RDW_HOLD = 2'd2
  } rdw_mode_e;

  // Number of lanes in one word.
  function automatic int lane_count(input int data_w, input int lane_w);
    return data_w / lane_w;
  endfunction

  // Width of the lane-enable port; a single-lane word keeps one unused bit.
  function automatic int lane_port_width(input int lanes);
    return (lanes < 2) ? 1 : lanes;
  endfunction

  // Lowest data bit covered by a lane.
  function automatic int lane_lsb(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction

  function automatic bit lane_width_legal(input int lane_w);
    return (lane_w == 5) || (lane_w == 8) || (lane_w == 9) || (lane_w == 10);
  endfunction

  function automatic bit width_multiple(input int data_w, input int lane_w);
    return (lane_w > 0) && (data_w >= lane_w) && ((data_w % lane_w) == 0);
  endfunction

  function automatic bit mode_legal(input rdw_mode_e mode);
    return (mode == RDW_NEW) || (mode == RDW_OLD) || (mode == RDW_HOLD);
  endfunction

endpackage

// File: rtl/bmr_lane_gate.sv
module bmr_lane_gate #(
  parameter int LANES     = 2,
  parameter int LANE_EN_W = 2
) (
  input  logic                 wr_en,
  input  logic [LANE_EN_W-1:0] lane_en,
  output logic [LANES-1:0]     strobe,
  output logic                 lanes_ignored
);

  generate
    if (LANES < 2) begin : g_single
      // One lane: the global enable alone decides.
      assign strobe        = {LANES{wr_en}};
      assign lanes_ignored = |lane_en;
    end else begin : g_multi
      // Each lane needs its own bit and the global enable.
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strobe[i] = wr_en & lane_en[i];
      end
      assign lanes_ignored = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bmr_store.sv
module bmr_store #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic [LANES-1:0]  strobe,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] stored
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Per-lane write; lanes without a strobe keep their bits.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strobe[i]) begin
        mem[waddr][bmr_pkg::lane_lsb(i, LANE_W) +: LANE_W] <=
          wdata[bmr_pkg::lane_lsb(i, LANE_W) +: LANE_W];
      end
    end
  end

  // Word held before any write of this cycle.
  assign stored = mem[raddr];

endmodule

// File: rtl/bmr_read_port.sv
module bmr_read_port
  import bmr_pkg::*;
#(
  parameter int        DATA_W = 16,
  parameter int        LANE_W = 8,
  parameter int        LANES  = 2,
  parameter rdw_mode_e MODE   = RDW_NEW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              collide,
  input  logic [LANES-1:0]  strobe,
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] next_word;

  // Word as it will be after this cycle's write: written lanes new, rest old.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_merge
      localparam int LSB = lane_lsb(i, LANE_W);
      assign new_word[LSB +: LANE_W] =
        strobe[i] ? wdata[LSB +: LANE_W] : stored[LSB +: LANE_W];
    end
  endgenerate

  generate
    if (MODE == RDW_NEW) begin : g_new
      always_comb next_word = collide ? new_word : stored;
    end else if (MODE == RDW_OLD) begin : g_old
      always_comb next_word = stored;
    end else begin : g_hold
      always_comb next_word = collide ? rd_data : stored;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= next_word;
    end
  end

endmodule

// File: rtl/bmr_masked_ram.sv
module bmr_masked_ram
  import bmr_pkg::*;
#(
  parameter int        DATA_W    = 16,
  parameter int        LANE_W    = 8,
  parameter int        DEPTH     = 16,
  parameter rdw_mode_e RDW_MODE  = RDW_NEW,
  localparam int       ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int       LANES     = lane_count(DATA_W, LANE_W),
  localparam int       LANE_EN_W = lane_port_width(LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 wr_en,
  input  logic [LANE_EN_W-1:0] wr_lanes,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rd_data
);

  // Elaboration-time parameter checks.
  generate
    if (!width_multiple(DATA_W, LANE_W)) begin : g_bad_width
      $fatal(1, "DATA_W must be a whole multiple of LANE_W");
    end
    if (!lane_width_legal(LANE_W)) begin : g_bad_lane
      $fatal(1, "LANE_W must be 5, 8, 9 or 10");
    end
    if (!mode_legal(RDW_MODE)) begin : g_bad_mode
      $fatal(1, "RDW_MODE is not a known collision mode");
    end
  endgenerate

  // Internal events, named for the checker.
  logic [LANES-1:0]  strobe;
  logic              lanes_ignored;
  logic              any_write;
  logic              same_addr;
  logic              collide;
  logic [DATA_W-1:0] stored_word;
  logic [DATA_W-1:0] new_word;

  bmr_lane_gate #(
    .LANES     (LANES),
    .LANE_EN_W (LANE_EN_W)
  ) u_gate (
    .wr_en         (wr_en),
    .lane_en       (wr_lanes),
    .strobe        (strobe),
    .lanes_ignored (lanes_ignored)
  );

  bmr_store #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk    (clk),
    .strobe (strobe),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .raddr  (rd_addr),
    .stored (stored_word)
  );

  assign any_write = |strobe;
  assign same_addr = (rd_addr == wr_addr);
  assign collide   = rd_en & same_addr & any_write;

  bmr_read_port #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .MODE   (RDW_MODE)
  ) u_rport (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .collide  (collide),
    .strobe   (strobe),
    .stored   (stored_word),
    .wdata    (wr_data),
    .new_word (new_word),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/bmr_masked_ram_chk.sv
module bmr_masked_ram_chk
  import bmr_pkg::*;
#(
  parameter int        DATA_W = 16,
  parameter int        LANES  = 2,
  parameter rdw_mode_e MODE   = RDW_NEW
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [LANES-1:0]  strobe,
  input logic              lanes_ignored,
  input logic              collide,
  input logic [DATA_W-1:0] stored_word,
  input logic [DATA_W-1:0] new_word,
  input logic [DATA_W-1:0] rd_data
);

  a_r1_no_write_without_enable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (strobe == '0));

  a_r9_single_lane_follows_enable: assert property (@(posedge clk) disable iff (rst)
    lanes_ignored |-> (strobe[0] == wr_en));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r3_plain_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !collide) |=> (rd_data == $past(stored_word)));

  a_r6_new_on_collision: assert property (@(posedge clk) disable iff (rst)
    ((MODE == RDW_NEW) && collide) |=> (rd_data == $past(new_word)));

  a_r7_old_on_collision: assert property (@(posedge clk) disable iff (rst)
    ((MODE == RDW_OLD) && collide) |=> (rd_data == $past(stored_word)));

  a_r8_hold_on_collision: assert property (@(posedge clk) disable iff (rst)
    ((MODE == RDW_HOLD) && collide) |=> $stable(rd_data));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

endmodule

bind bmr_masked_ram bmr_masked_ram_chk #(
  .DATA_W (DATA_W),
  .LANES  (LANES),
  .MODE   (RDW_MODE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .strobe        (strobe),
  .lanes_ignored (lanes_ignored),
  .collide       (collide),
  .stored_word   (stored_word),
  .new_word      (new_word),
  .rd_data       (rd_data)
);

// File: tb/bmr_masked_ram_test.sv
module bmr_masked_ram_test;
  import bmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_lanes = '0;
  logic [3:0]  rd_addr = '0;
  logic        rd_en = 1'b0;

  logic [15:0] dout_a;
  logic [14:0] dout_b;
  logic [17:0] dout_c;
  logic [9:0]  dout_d;
  logic [19:0] got [4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Configuration of the four copies: lane width, word width, mode.
  int lwv [4] = '{8, 5, 9, 10};
  int dwv [4] = '{16, 15, 18, 10};
  int mdv [4] = '{0, 1, 2, 0};

  logic [19:0] model [4][16];
  logic [19:0] expd  [4];

  always #2ns clk = ~clk;

  bmr_masked_ram #(.DATA_W(16), .LANE_W(8), .DEPTH(16), .RDW_MODE(RDW_NEW)) uut (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data[15:0]), .wr_en(wr_en),
    .wr_lanes(wr_lanes[1:0]), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(dout_a));

  bmr_masked_ram #(.DATA_W(15), .LANE_W(5), .DEPTH(16), .RDW_MODE(RDW_OLD)) uut_old (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data[14:0]), .wr_en(wr_en),
    .wr_lanes(wr_lanes[2:0]), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(dout_b));

  bmr_masked_ram #(.DATA_W(18), .LANE_W(9), .DEPTH(16), .RDW_MODE(RDW_HOLD)) uut_hold (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data[17:0]), .wr_en(wr_en),
    .wr_lanes(wr_lanes[1:0]), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(dout_c));

  bmr_masked_ram #(.DATA_W(10), .LANE_W(10), .DEPTH(16), .RDW_MODE(RDW_NEW)) uut_one (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data[9:0]), .wr_en(wr_en),
    .wr_lanes(wr_lanes[0:0]), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(dout_d));

  assign got[0] = {4'b0, dout_a};
  assign got[1] = {5'b0, dout_b};
  assign got[2] = {2'b0, dout_c};
  assign got[3] = {10'b0, dout_d};

  task automatic compare(input int k, input string tag);
    checks++;
    if (got[k] !== expd[k]) begin
      errors++;
      $display("FAIL %s copy%0d got %h expected %h", tag, k, got[k], expd[k]);
    end
  endtask

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic do_cycle(input logic [3:0] wa, input logic [19:0] wd, input logic we,
                          input logic [3:0] le, input logic [3:0] ra, input logic re,
                          input string tag);
    string tg [4];
    wr_addr = wa; wr_data = wd; wr_en = we; wr_lanes = le; rd_addr = ra; rd_en = re;
    for (int k = 0; k < 4; k++) begin
      int nl;
      logic [19:0] st;
      logic [19:0] merged;
      logic [19:0] after;
      bit anyw;
      bit hit;
      nl = dwv[k] / lwv[k];
      st = model[k][ra];
      merged = st;
      after = model[k][wa];
      anyw = 1'b0;
      for (int b = 0; b < dwv[k]; b++) begin
        if (we && (nl < 2 || le[b / lwv[k]])) begin
          anyw = 1'b1;
          after[b] = wd[b];
          merged[b] = wd[b];
        end
      end
      hit = re && (wa == ra) && anyw;
      if (!re) begin
        tg[k] = "R5";
      end else if (!hit) begin
        expd[k] = st;
        tg[k] = "R3";
      end else if (mdv[k] == 0) begin
        expd[k] = merged;
        tg[k] = "R6";
      end else if (mdv[k] == 1) begin
        expd[k] = st;
        tg[k] = "R7";
      end else begin
        tg[k] = "R8";
      end
      if (tag != "") tg[k] = tag;
      model[k][wa] = after;
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) compare(k, tg[k]);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a++) do_cycle(4'(a), 20'h0, 1'b0, 4'h0, 4'(a), 1'b1, tag);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      expd[k] = '0;
      for (int a = 0; a < 16; a++) model[k][a] = '0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) compare(k, "R10");
    rst = 1'b0;

    // Fill every word with all lanes enabled, reads idle (output holds 0).
    for (int a = 0; a < 16; a++)
      do_cycle(4'(a), 20'(32'hB5A3D * (a + 1)), 1'b1, 4'hF, 4'(a), 1'b0, "R5");
    read_all("R3");

    // R2: low lane only, then read back (16/8 copy expects FF34).
    do_cycle(4'd3, 20'hFFFFF, 1'b1, 4'hF, 4'd3, 1'b0, "R2");
    do_cycle(4'd3, 20'h01234, 1'b1, 4'b0001, 4'd3, 1'b0, "R2");
    do_cycle(4'd0, 20'h0, 1'b0, 4'h0, 4'd3, 1'b1, "R2");
    checks++;
    if (dout_a !== 16'hFF34) begin
      errors++;
      $display("FAIL R2 low-lane write got %h expected %h", dout_a, 16'hFF34);
    end

    // R1: lane bits without the global enable change nothing.
    do_cycle(4'd5, 20'h5A5A5, 1'b0, 4'hF, 4'd5, 1'b1, "R1");
    do_cycle(4'd0, 20'h0, 1'b0, 4'h0, 4'd5, 1'b1, "R1");

    // R9: single-lane copy writes with no lane bits; others do not.
    do_cycle(4'd6, 20'h00ABC, 1'b1, 4'h0, 4'd6, 1'b0, "R9");
    do_cycle(4'd0, 20'h0, 1'b0, 4'h0, 4'd6, 1'b1, "R9");

    // R4: middle lane of the three-lane 5-bit word, written alone.
    do_cycle(4'd7, 20'hFFFFF, 1'b1, 4'hF, 4'd7, 1'b0, "R4");
    do_cycle(4'd7, 20'h00000, 1'b1, 4'b0010, 4'd7, 1'b0, "R4");
    do_cycle(4'd0, 20'h0, 1'b0, 4'h0, 4'd7, 1'b1, "R4");

    // Sweep: every lane pattern, enable on/off, every address.
    for (int it = 0; it < 4; it++) begin
      for (int a = 0; a < 16; a++) begin
        for (int le = 0; le < 16; le++) begin
          for (int we = 0; we < 2; we++) begin
            logic [3:0] ra;
            logic re;
            logic [19:0] wd;
            ra = (((le + it) % 3) != 0) ? 4'(a) : 4'(a ^ 5);
            re = (((a + le + we + it) % 5) != 0);
            wd = 20'((it * 32'h9E37) ^ (a * 32'h3B1) ^ (le * 32'h1F5C3) ^ (we * 32'hA0A0));
            do_cycle(4'(a), wd, 1'(we), 4'(le), ra, re, "");
          end
        end
      end
    end

    // R10: reset clears the output but keeps memory.
    rst = 1'b1;
    wr_en = 1'b0; rd_en = 1'b1;
    for (int k = 0; k < 4; k++) expd[k] = '0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) compare(k, "R10");
    rst = 1'b0;
    read_all("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule